// File: doc/BRIEF.md
# Windowed Framebuffer Address Generator

This block sits behind a display command decoder. The decoder sends it pixel bytes with a write strobe, and the block stores each byte in an on-chip framebuffer of 64 byte columns by 80 rows, which is 5120 bytes. Every byte holds two 4-bit pixels. A byte goes to address `column + row * 64`. Once a byte is written, the cursor moves to the next position inside a rectangular window that the decoder has programmed. In horizontal order the column steps and a column overflow carries into the row. In vertical order the row steps and a row overflow carries into the column.

The decoder loads the window bounds with a one-cycle pulse. It also loads a remap byte, and only bit 2 of that byte changes the addressing. The write port of the framebuffer is also driven out of the block, so a neighbour can mirror or snoop the writes. A second port reads the framebuffer for scanout. A redraw-needed flag records that the picture has changed, and it stays set until the scanout side reports that a full frame has been sent.

Top module: `fbw_addr_gen`

## Requirements
- R1: After reset the cursor is at column 0, row 0. The window covers columns 0..63 and rows 0..79. The remap byte is 0, which selects horizontal order, and `redraw` is low.
- R2: While `wr_en` is high, `mem_we` is high in the same cycle. `mem_wdata` equals `wr_data`, and `mem_addr` equals `cur_col + cur_row*64` taken at the position before the write. The byte is stored in the framebuffer at that address.
- R3: Horizontal order applies when remap bit 2 is 0. Each write adds 1 to the column. If the column passes the column end, it goes back to the column start and the row adds 1. If the row then passes the row end, it goes back to the row start.
- R4: Vertical order applies when remap bit 2 is 1. Each write adds 1 to the row. If the row passes the row end, it goes back to the row start and the column adds 1. If the column then passes the column end, it goes back to the column start.
- R5: A `win_load` pulse stores column bounds as `value mod 64` and row bounds as `value mod 80`. On the next cycle the cursor sits at the new column start and row start.
- R6: If `win_load` and `wr_en` are high in the same cycle, the byte is written at the position before the load. After that cycle the cursor is at the new start position and does not advance.
- R7: A write sets `redraw` on the following cycle. A `frame_done` pulse clears it. If a write and `frame_done` happen in the same cycle, the flag is set.
- R8: `remap_load` stores `remap_in`, and the stored value appears on `remap_o`. Bits other than bit 2 do not affect the address order, so 0xFB gives horizontal order.
- R9: The scanout port returns the byte at `rd_addr` one clock after the address is applied. A read is registered, so `rd_data` does not change during the cycle in which the address is applied.
- R10: If there is no write and no load, the cursor holds its position and `mem_we` stays low. The row is always below 80.
- R11: If a start is set above its end, each step of that axis overflows at once. In horizontal order with column start above column end, every write returns to the column start and carries into the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Pixel byte write strobe |
| wr_data | input | 8 | Pixel byte (two 4-bit pixels) |
| win_load | input | 1 | Load window bounds and move cursor to starts |
| col_first | input | 8 | Column start, taken modulo 64 |
| col_last | input | 8 | Column end, taken modulo 64 |
| row_first | input | 8 | Row start, taken modulo 80 |
| row_last | input | 8 | Row end, taken modulo 80 |
| remap_load | input | 1 | Store `remap_in` |
| remap_in | input | 8 | Remap byte; bit 2 selects vertical order |
| frame_done | input | 1 | Scanout finished a frame; clears redraw |
| rd_addr | input | 13 | Scanout read address |
| mem_we | output | 1 | Framebuffer write enable |
| mem_addr | output | 13 | Framebuffer write address |
| mem_wdata | output | 8 | Framebuffer write data |
| rd_data | output | 8 | Scanout read data, one cycle after `rd_addr` |
| redraw | output | 1 | Picture changed since last completed frame |
| cur_col | output | 6 | Current cursor column |
| cur_row | output | 7 | Current cursor row |
| remap_o | output | 8 | Stored remap byte |

## Verification
The write port is combinational. `mem_we`, `mem_addr` and `mem_wdata` are therefore checked 1 ns after the strobe is driven, in the same cycle and before the clock edge. The cursor, the stored bounds, the remap byte and `redraw` are registers that change on the next edge, so these are checked at the falling edge that follows. Scanout data takes one cycle. The bench checks that `rd_data` has not changed just after a new address is applied, and that it holds the expected byte one falling edge later.

// File: rtl/fbw_pkg.sv
// Shared constants and types for the windowed framebuffer address generator.
// Assumes a byte-per-two-pixel framebuffer addressed as column + row*columns.
package fbw_pkg;
    localparam int unsigned FBW_COLS      = 64;
    localparam int unsigned FBW_ROWS      = 80;
    localparam int unsigned FBW_BYTE_W    = 8;
    localparam int unsigned FBW_VERT_BIT  = 2;

    typedef enum logic {
        SCAN_HORIZ = 1'b0,
        SCAN_VERT  = 1'b1
    } scan_order_e;
endpackage

// File: rtl/fbw_axis_step.sv
// One axis of the cursor. The module adds bump to cur and wraps to first
// when the result passes last. Assumes first, last and cur all lie below the
// axis limit; the sum is formed one bit wider, so stepping from the top value
// still compares correctly.
module fbw_axis_step #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last,
    input  logic         bump,
    output logic [W-1:0] nxt,
    output logic         over
);
    logic [W:0] sum;

    // Step the coordinate and detect overflow beyond the window end.
    always_comb begin
        sum  = {1'b0, cur} + {{W{1'b0}}, bump};
        over = (sum > {1'b0, last});
        nxt  = over ? first : sum[W-1:0];
    end
endmodule

// File: rtl/fbw_cursor.sv
// Cursor and window state. The module holds the window bounds, the remap byte
// and the current column/row, and advances the position after each write in
// horizontal or vertical order. A load moves the cursor to the new starts and
// overrides the advance. Assumes COLS and ROWS are at most 2**BND_W.
module fbw_cursor
    import fbw_pkg::*;
#(
    parameter int unsigned COLS  = FBW_COLS,
    parameter int unsigned ROWS  = FBW_ROWS,
    parameter int unsigned BND_W = 8,
    localparam int unsigned COL_W = $clog2(COLS),
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             win_load,
    input  logic [BND_W-1:0] col_first,
    input  logic [BND_W-1:0] col_last,
    input  logic [BND_W-1:0] row_first,
    input  logic [BND_W-1:0] row_last,
    input  logic             remap_load,
    input  logic [7:0]       remap_in,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] row_q,
    output logic [7:0]       remap_q
);
    logic [COL_W-1:0] col_lo, col_hi, col_ld, col_hi_ld;
    logic [ROW_W-1:0] row_lo, row_hi, row_ld, row_hi_ld;
    logic [COL_W-1:0] col_p_nxt, col_s_nxt, col_nxt;
    logic [ROW_W-1:0] row_p_nxt, row_s_nxt, row_nxt;
    logic             col_p_over, row_p_over, col_s_over, row_s_over;
    scan_order_e      order;

    // Reduce incoming bounds into the legal coordinate ranges.
    always_comb begin
        col_ld    = COL_W'(col_first % COLS);
        col_hi_ld = COL_W'(col_last  % COLS);
        row_ld    = ROW_W'(row_first % ROWS);
        row_hi_ld = ROW_W'(row_last  % ROWS);
    end

    assign order = scan_order_e'(remap_q[FBW_VERT_BIT]);

    // Primary-role steps always bump; secondary-role steps take the other
    // axis' overflow, so there is no combinational loop between axes.
    fbw_axis_step #(.W(COL_W)) u_col_p (
        .cur(col_q), .first(col_lo), .last(col_hi), .bump(1'b1),
        .nxt(col_p_nxt), .over(col_p_over));
    fbw_axis_step #(.W(ROW_W)) u_row_p (
        .cur(row_q), .first(row_lo), .last(row_hi), .bump(1'b1),
        .nxt(row_p_nxt), .over(row_p_over));
    fbw_axis_step #(.W(COL_W)) u_col_s (
        .cur(col_q), .first(col_lo), .last(col_hi), .bump(row_p_over),
        .nxt(col_s_nxt), .over(col_s_over));
    fbw_axis_step #(.W(ROW_W)) u_row_s (
        .cur(row_q), .first(row_lo), .last(row_hi), .bump(col_p_over),
        .nxt(row_s_nxt), .over(row_s_over));

    // Choose the post-write position for the active scan order.
    always_comb begin
        if (order == SCAN_VERT) begin
            row_nxt = row_p_nxt;
            col_nxt = col_s_nxt;
        end else begin
            col_nxt = col_p_nxt;
            row_nxt = row_s_nxt;
        end
    end

    // Window bounds and remap byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_lo  <= '0;
            col_hi  <= COL_W'(COLS - 1);
            row_lo  <= '0;
            row_hi  <= ROW_W'(ROWS - 1);
            remap_q <= '0;
        end else begin
            if (win_load) begin
                col_lo <= col_ld;
                col_hi <= col_hi_ld;
                row_lo <= row_ld;
                row_hi <= row_hi_ld;
            end
            if (remap_load) remap_q <= remap_in;
        end
    end

    // Cursor position: load wins over the post-write advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (win_load) begin
            col_q <= col_ld;
            row_q <= row_ld;
        end else if (wr_en) begin
            col_q <= col_nxt;
            row_q <= row_nxt;
        end
    end

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_q < ROW_W'(ROWS)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !win_load) |=> ($stable(col_q) && $stable(row_q))); // R10
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        win_load |=> (col_q == $past(col_ld) && row_q == $past(row_ld))); // R5
    AST_HORIZ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !win_load && !remap_q[FBW_VERT_BIT] && col_q < col_hi && col_q >= col_lo)
        |=> (col_q == $past(col_q) + 1'b1 && $stable(row_q))); // R3
    AST_VERT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !win_load && remap_q[FBW_VERT_BIT] && row_q < row_hi && row_q >= row_lo)
        |=> (row_q == $past(row_q) + 1'b1 && $stable(col_q))); // R4
endmodule

// File: rtl/fbw_ram.sv
// Framebuffer storage: one write port and one registered read port.
// A read at the written address in the same cycle returns the old byte.
module fbw_ram #(
    parameter int unsigned DEPTH = 5120,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store the incoming byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered scanout read, one cycle of latency.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/fbw_addr_gen.sv
// Windowed framebuffer address generator. The module writes pixel bytes at
// column + row*COLS, advances the cursor inside the programmed window,
// exposes the write port, owns the framebuffer with a 1-cycle scanout read
// port, and keeps a redraw-needed flag. Assumes the scanout side pulses
// frame_done once per completed frame.
module fbw_addr_gen
    import fbw_pkg::*;
#(
    parameter int unsigned COLS  = FBW_COLS,
    parameter int unsigned ROWS  = FBW_ROWS,
    parameter int unsigned BND_W = 8,
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned DEPTH  = COLS * ROWS,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned DW     = FBW_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              win_load,
    input  logic [BND_W-1:0]  col_first,
    input  logic [BND_W-1:0]  col_last,
    input  logic [BND_W-1:0]  row_first,
    input  logic [BND_W-1:0]  row_last,
    input  logic              remap_load,
    input  logic [7:0]        remap_in,
    input  logic              frame_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     rd_data,
    output logic              redraw,
    output logic [COL_W-1:0]  cur_col,
    output logic [ROW_W-1:0]  cur_row,
    output logic [7:0]        remap_o
);
    logic redraw_q;

    fbw_cursor #(.COLS(COLS), .ROWS(ROWS), .BND_W(BND_W)) u_cursor (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .win_load(win_load),
        .col_first(col_first), .col_last(col_last),
        .row_first(row_first), .row_last(row_last),
        .remap_load(remap_load), .remap_in(remap_in),
        .col_q(cur_col), .row_q(cur_row), .remap_q(remap_o));

    // Write port uses the position held before any same-cycle load.
    always_comb begin
        mem_we    = wr_en;
        mem_wdata = wr_data;
        mem_addr  = ADDR_W'(cur_row) * ADDR_W'(COLS) + ADDR_W'(cur_col);
    end

    fbw_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data));

    // Redraw flag: a write sets it, frame completion clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          redraw_q <= 1'b0;
        else if (wr_en)      redraw_q <= 1'b1;
        else if (frame_done) redraw_q <= 1'b0;
    end
    assign redraw = redraw_q;

    AST_REDRAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> redraw); // R7
    AST_REDRAW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !wr_en) |=> !redraw); // R7
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr < ADDR_W'(DEPTH))); // R2
endmodule

// File: tb/fbw_addr_gen_tb.sv
// Directed bench for the windowed framebuffer address generator.
module fbw_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        win_load = 1'b0;
    logic [7:0]  col_first = '0, col_last = '0, row_first = '0, row_last = '0;
    logic        remap_load = 1'b0;
    logic [7:0]  remap_in = '0;
    logic        frame_done = 1'b0;
    logic [12:0] rd_addr = '0;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata, rd_data, remap_o;
    logic        redraw;
    logic [5:0]  cur_col;
    logic [6:0]  cur_row;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    fbw_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .win_load(win_load), .col_first(col_first), .col_last(col_last),
        .row_first(row_first), .row_last(row_last),
        .remap_load(remap_load), .remap_in(remap_in), .frame_done(frame_done),
        .rd_addr(rd_addr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_data(rd_data), .redraw(redraw),
        .cur_col(cur_col), .cur_row(cur_row), .remap_o(remap_o));

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input int exp_addr, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        #1;
        chk(req, "mem_we", int'(mem_we), 1);
        chk(req, "mem_addr", int'(mem_addr), exp_addr);
        chk(req, "mem_wdata", int'(mem_wdata), int'(d));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_window(input int cf, input int cl, input int rf, input int rl);
        @(negedge clk);
        win_load = 1'b1;
        col_first = 8'(cf); col_last = 8'(cl); row_first = 8'(rf); row_last = 8'(rl);
        @(negedge clk);
        win_load = 1'b0;
    endtask

    task automatic set_remap(input logic [7:0] v);
        @(negedge clk);
        remap_load = 1'b1; remap_in = v;
        @(negedge clk);
        remap_load = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "cur_col", int'(cur_col), 0);
        chk("R1", "cur_row", int'(cur_row), 0);
        chk("R1", "redraw", int'(redraw), 0);
        chk("R1", "remap_o", int'(remap_o), 0);
        chk("R1", "mem_we", int'(mem_we), 0);
        // full window: first write at 0, next column 1
        put(8'h11, 0, "R1");
        chk("R1", "cur_col after write", int'(cur_col), 1);
    endtask

    task automatic t_horiz();
        set_window(62, 63, 78, 79);
        chk("R3", "start col", int'(cur_col), 62);
        chk("R3", "start row", int'(cur_row), 78);
        put(8'hA1, 78*64+62, "R3");
        put(8'hA2, 78*64+63, "R3");
        put(8'hA3, 79*64+62, "R3");
        put(8'hA4, 79*64+63, "R3");
        put(8'hA5, 78*64+62, "R3");
        chk("R10", "row stays below 80", int'(cur_row < 7'd80), 1);
    endtask

    task automatic t_read();
        @(negedge clk); rd_addr = 13'(79*64+63);
        @(negedge clk);
        chk("R9", "rd_data 5119", int'(rd_data), 8'hA4);
        rd_addr = 13'(78*64+63);
        #1;
        chk("R9", "rd_data before edge", int'(rd_data), 8'hA4);
        @(negedge clk);
        chk("R9", "rd_data 5055", int'(rd_data), 8'hA2);
        rd_addr = 13'(78*64+62);
        @(negedge clk);
        chk("R2", "overwritten byte", int'(rd_data), 8'hA5);
    endtask

    task automatic t_vert();
        set_remap(8'h04);
        set_window(10, 11, 5, 6);
        put(8'hB0, 5*64+10, "R4");
        put(8'hB1, 6*64+10, "R4");
        put(8'hB2, 5*64+11, "R4");
        put(8'hB3, 6*64+11, "R4");
        put(8'hB4, 5*64+10, "R4");
    endtask

    task automatic t_other_bits();
        set_remap(8'hFB);
        chk("R8", "remap_o", int'(remap_o), 8'hFB);
        set_window(0, 1, 0, 0);
        put(8'hC0, 0, "R8");
        put(8'hC1, 1, "R8");
        put(8'hC2, 0, "R8");
    endtask

    task automatic t_modulo();
        set_window(8'h45, 8'hC7, 85, 200);
        chk("R5", "col start mod 64", int'(cur_col), 8'h45 % 64);
        chk("R5", "row start mod 80", int'(cur_row), 85 % 80);
        put(8'hD0, 5*64+5, "R5");
        chk("R5", "col after write", int'(cur_col), 6);
    endtask

    task automatic t_load_and_write();
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hE0;
        win_load = 1'b1; col_first = 8'd20; col_last = 8'd30;
        row_first = 8'd10; row_last = 8'd20;
        #1;
        chk("R6", "addr uses old position", int'(mem_addr), 5*64+6);
        @(negedge clk);
        wr_en = 1'b0; win_load = 1'b0;
        chk("R6", "col at new start", int'(cur_col), 20);
        chk("R6", "row at new start", int'(cur_row), 10);
        put(8'hE1, 10*64+20, "R6");
    endtask

    task automatic t_hold();
        logic [5:0] c0;
        logic [6:0] r0;
        c0 = cur_col; r0 = cur_row;
        repeat (3) @(negedge clk);
        chk("R10", "col held", int'(cur_col), int'(c0));
        chk("R10", "row held", int'(cur_row), int'(r0));
        chk("R10", "no write", int'(mem_we), 0);
    endtask

    task automatic t_start_above_end();
        set_window(5, 2, 3, 4);
        put(8'hF0, 3*64+5, "R11");
        chk("R11", "col back to start", int'(cur_col), 5);
        chk("R11", "row carried", int'(cur_row), 4);
        put(8'hF1, 4*64+5, "R11");
        chk("R11", "row wrapped", int'(cur_row), 3);
    endtask

    task automatic t_redraw();
        chk("R7", "redraw set by writes", int'(redraw), 1);
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R7", "redraw cleared", int'(redraw), 0);
        @(negedge clk); frame_done = 1'b1; wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk); frame_done = 1'b0; wr_en = 1'b0;
        chk("R7", "write wins over frame_done", int'(redraw), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_horiz();
        t_read();
        t_vert();
        t_other_bits();
        t_modulo();
        t_load_and_write();
        t_hold();
        t_start_above_end();
        t_redraw();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule